// File: doc/BRIEF.md
# Per-Pin Interrupt Detector

This block watches a wide vector of input bits that are already synchronized to its clock. Each bit can be set to flag a rising edge, a falling edge, either edge, a high level or a low level. When the chosen condition occurs on a pin whose enable bit is set, a sticky flag for that pin goes high. All flags are ORed onto a single interrupt line. Software reads the flags and clears each one by writing a 1 to it.

The pins are grouped into banks of `BANK_W` bits, and the last bank may be only partly filled. Each bank has five registers, reached through a small write/read port: enable, polarity, level select, dual-edge select and flag. Reads are combinational. Writes take effect at the next rising clock edge.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset every register in every bank reads 0 and `irq_out` is low.
- R2: With level select 0 and dual select 0, polarity 1 flags a 0-to-1 change and polarity 0 flags a 1-to-0 change. An edge is a difference between the input and its value at the previous clock edge, and the flag is visible after that edge. A steady input never flags.
- R3: With level select 1 and dual select 0, polarity 1 flags while the input is 1 and polarity 0 flags while it is 0. A flag cleared while the condition persists reads 0 for one cycle and is set again by the following edge.
- R4: With dual select 1, both kinds of change set the flag and a steady input does not, whatever the polarity and level select bits hold.
- R5: Writing a 1 to a flag bit clears it, and writing a 0 leaves it unchanged. A clear wins over an event on the same pin at the same edge.
- R6: A flag can only become set while its pin's enable bit is 1. Clearing the enable bit leaves an existing flag unchanged.
- R7: `irq_out` is high exactly when at least one flag bit in any bank is 1.
- R8: Address bits [ADDR_W-1:3] select the bank and bits [2:0] select the register: 0 enable, 1 polarity, 2 level select, 3 dual select, 4 flag. Pin n sits in bank n / BANK_W at bit n % BANK_W. Bits beyond the last pin, banks past the last one and register codes 5 to 7 read 0 and ignore writes.
- R9: With no register write, no flag bit goes from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | NUM_PINS | Synchronized pin inputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Bank and register select |
| reg_wdata | input | BANK_W | Write data |
| reg_rdata | output | BANK_W | Combinational read data |
| irq_out | output | 1 | OR of all flag bits |

## Verification
A wrong polarity, level or dual bit in a pin's configuration appears at the flag register and at `irq_out` one clock edge after the input changes. The symptom is a missing flag, or a flag on a steady or opposite-direction input. A stale previous-value register makes an edge-mode pin flag or miss in the same cycle. A flag register that loses or gains bits on its own appears on the next read and on `irq_out` as soon as the last set bit changes. The bench therefore samples both the flag word and `irq_out` exactly one edge after each stimulus and clear.

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NUM_PINS = 80,
  parameter int BANK_W   = 32,
  parameter int ADDR_W   = $clog2((NUM_PINS + BANK_W - 1) / BANK_W) + 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [BANK_W-1:0]   reg_wdata,
  output logic [BANK_W-1:0]   reg_rdata,
  output logic                irq_out
);
  localparam int BANKS   = (NUM_PINS + BANK_W - 1) / BANK_W;
  localparam int SPAN    = BANKS * BANK_W;
  localparam int BANK_AW = ADDR_W - 3;

  localparam logic [2:0] F_EN   = 3'd0;
  localparam logic [2:0] F_POL  = 3'd1;
  localparam logic [2:0] F_LVL  = 3'd2;
  localparam logic [2:0] F_DUAL = 3'd3;
  localparam logic [2:0] F_FLAG = 3'd4;

  logic [NUM_PINS-1:0] en_q, pol_q, lvl_q, dual_q, flag_q, prev_q, hit;
  logic [2:0]          fld;
  logic [BANK_AW-1:0]  bank_sel;

  assign fld      = reg_addr[2:0];
  assign bank_sel = reg_addr[ADDR_W-1:3];

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    localparam int B = n / BANK_W;
    localparam int K = n % BANK_W;
    logic here, wbit, rise, fall;
    logic en_r, pol_r, lvl_r, dual_r, flag_r, prev_r;

    assign here = reg_we && (bank_sel == BANK_AW'(B));
    assign wbit = reg_wdata[K];
    assign rise = pin_in[n] & ~prev_r;
    assign fall = ~pin_in[n] & prev_r;
    assign hit[n] = dual_r ? (rise | fall) :
                    lvl_r  ? (pin_in[n] ~^ pol_r) :
                    (pol_r ? rise : fall);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_r   <= 1'b0;
        pol_r  <= 1'b0;
        lvl_r  <= 1'b0;
        dual_r <= 1'b0;
        flag_r <= 1'b0;
        prev_r <= 1'b0;
      end else begin
        prev_r <= pin_in[n];
        if (here && fld == F_EN)   en_r   <= wbit;
        if (here && fld == F_POL)  pol_r  <= wbit;
        if (here && fld == F_LVL)  lvl_r  <= wbit;
        if (here && fld == F_DUAL) dual_r <= wbit;
        flag_r <= (flag_r | (hit[n] & en_r)) & ~(here && fld == F_FLAG && wbit);
      end
    end

    assign en_q[n]   = en_r;
    assign pol_q[n]  = pol_r;
    assign lvl_q[n]  = lvl_r;
    assign dual_q[n] = dual_r;
    assign flag_q[n] = flag_r;
    assign prev_q[n] = prev_r;
  end

  assign irq_out = |flag_q;

  logic [SPAN-1:0] en_w, pol_w, lvl_w, dual_w, flag_w;
  assign en_w   = SPAN'(en_q);
  assign pol_w  = SPAN'(pol_q);
  assign lvl_w  = SPAN'(lvl_q);
  assign dual_w = SPAN'(dual_q);
  assign flag_w = SPAN'(flag_q);

  always_comb begin
    reg_rdata = '0;
    if (int'(bank_sel) < BANKS) begin
      case (fld)
        F_EN:    reg_rdata = en_w[int'(bank_sel)*BANK_W +: BANK_W];
        F_POL:   reg_rdata = pol_w[int'(bank_sel)*BANK_W +: BANK_W];
        F_LVL:   reg_rdata = lvl_w[int'(bank_sel)*BANK_W +: BANK_W];
        F_DUAL:  reg_rdata = dual_w[int'(bank_sel)*BANK_W +: BANK_W];
        F_FLAG:  reg_rdata = flag_w[int'(bank_sel)*BANK_W +: BANK_W];
        default: reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int NUM_PINS = 80,
  parameter int BANK_W   = 32,
  parameter int ADDR_W   = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] pin_in,
  input logic                reg_we,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [BANK_W-1:0]   reg_wdata,
  input logic                irq_out,
  input logic [NUM_PINS-1:0] en_q,
  input logic [NUM_PINS-1:0] lvl_q,
  input logic [NUM_PINS-1:0] dual_q,
  input logic [NUM_PINS-1:0] flag_q
);
  localparam int B0W = (NUM_PINS < BANK_W) ? NUM_PINS : BANK_W;
  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;

  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    age != 2'd0 |-> ((flag_q & ~$past(flag_q) & ~$past(en_q)) == '0));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && !$past(reg_we)) |-> ((~flag_q & $past(flag_q)) == '0));

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && $past(reg_we) && $past(reg_addr) == ADDR_W'(4))
      |-> ((flag_q[B0W-1:0] & $past(reg_wdata[B0W-1:0])) == '0));

  p_irq_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && $rose(irq_out)) |-> ($past(en_q) != '0));

  p_edge_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
    age == 2'd3 |-> ((flag_q & ~$past(flag_q)
                      & ~($past(lvl_q) & ~$past(dual_q))
                      & ~($past(pin_in) ^ $past(pin_in, 2))) == '0));
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(
  .NUM_PINS(NUM_PINS), .BANK_W(BANK_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq_out(irq_out),
  .en_q(en_q), .lvl_q(lvl_q), .dual_q(dual_q), .flag_q(flag_q)
);

// File: tb/gpio_irq_detect_bench.sv
`timescale 1ns/100ps
module gpio_irq_detect_bench;
  localparam int NP = 80;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq_out;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_irq_detect u_gpio_irq_detect (
    .clk(clk), .rst_n(rst_n), .pin_in(pins), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  // {pin[6:0], polarity, level, dual, start, end, expected flag}
  localparam logic [12:0] VEC [16] = '{
    {7'd5,  6'b100011}, {7'd40, 6'b100100}, {7'd79, 6'b100110},
    {7'd0,  6'b000101}, {7'd31, 6'b000010}, {7'd32, 6'b000000},
    {7'd63, 6'b110011}, {7'd64, 6'b110100}, {7'd12, 6'b110111},
    {7'd50, 6'b010001}, {7'd70, 6'b010010}, {7'd1,  6'b010101},
    {7'd33, 6'b001011}, {7'd65, 6'b101101}, {7'd78, 6'b111110},
    {7'd20, 6'b001000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int bank, input int fld, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1;
    reg_addr = {bank[1:0], fld[2:0]};
    reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int bank, input int fld, output logic [31:0] v);
    reg_addr = {bank[1:0], fld[2:0]};
    #1;
    v = reg_rdata;
  endtask

  task automatic quiet_all();
    for (int b = 0; b < 3; b++) begin
      wr(b, 0, 32'h0);
      wr(b, 4, 32'hFFFF_FFFF);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state of every register
    for (int b = 0; b < 4; b++)
      for (int f = 0; f < 5; f++) begin
        rd(b, f, v);
        chk("R1 reset read", v, 32'h0);
      end
    chk("R1 irq after reset", {31'h0, irq_out}, 32'h0);

    // Vector table: R2 edge, R3 level, R4 dual
    for (int i = 0; i < 16; i++) begin
      int p, bank, bitp;
      logic pol, lvl, dual, st, en, ex;
      string tag;
      p = int'(VEC[i][12:6]);
      {pol, lvl, dual, st, en, ex} = VEC[i][5:0];
      bank = p >> 5;
      bitp = p & 31;
      tag = dual ? "R4 dual vector" : (lvl ? "R3 level vector" : "R2 edge vector");
      quiet_all();
      wr(bank, 1, 32'(pol) << bitp);
      wr(bank, 2, 32'(lvl) << bitp);
      wr(bank, 3, 32'(dual) << bitp);
      pins[p] = st;
      wr(bank, 0, 32'h1 << bitp);
      @(negedge clk);
      @(negedge clk);
      reg_we = 1'b1;
      reg_addr = {bank[1:0], 3'd4};
      reg_wdata = 32'hFFFF_FFFF;
      @(negedge clk);
      reg_we = 1'b0;
      pins[p] = en;
      @(negedge clk);
      rd(bank, 4, v);
      chk(tag, v, 32'(ex) << bitp);
      chk({tag, " irq R7"}, {31'h0, irq_out}, {31'h0, ex});
      pins[p] = 1'b0;
    end

    // R8: partial bank, missing bank, unused register code
    quiet_all();
    wr(2, 0, 32'hFFFF_FFFF);
    rd(2, 0, v);
    chk("R8 partial bank enable", v, 32'h0000_FFFF);
    wr(3, 0, 32'hFFFF_FFFF);
    rd(3, 0, v);
    chk("R8 absent bank", v, 32'h0);
    wr(0, 5, 32'hFFFF_FFFF);
    rd(0, 5, v);
    chk("R8 unused register", v, 32'h0);
    rd(0, 0, v);
    chk("R8 unused code leaves enable", v, 32'h0);
    wr(2, 0, 32'h0);

    // R3 and R5: clear wins, level re-sets next edge
    quiet_all();
    wr(0, 1, 32'h1 << 10);
    wr(0, 2, 32'h1 << 10);
    wr(0, 3, 32'h0);
    pins[10] = 1'b1;
    wr(0, 0, 32'h1 << 10);
    @(negedge clk);
    wr(0, 4, 32'h1 << 10);
    rd(0, 4, v);
    chk("R5 clear wins over level", v, 32'h0);
    @(negedge clk);
    rd(0, 4, v);
    chk("R3 level re-sets", v, 32'h1 << 10);
    pins[10] = 1'b0;

    // R6: enable gating
    quiet_all();
    chk("R7 irq low when clear", {31'h0, irq_out}, 32'h0);
    wr(1, 1, 32'h1 << 13);
    wr(1, 2, 32'h0);
    wr(1, 3, 32'h0);
    pins[45] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd(1, 4, v);
    chk("R6 disabled pin", v, 32'h0);
    chk("R6 disabled irq", {31'h0, irq_out}, 32'h0);
    pins[45] = 1'b0;
    wr(1, 0, 32'h1 << 13);
    pins[45] = 1'b1;
    @(negedge clk);
    rd(1, 4, v);
    chk("R2 rise after enable", v, 32'h1 << 13);
    pins[45] = 1'b0;
    repeat (4) @(negedge clk);
    rd(1, 4, v);
    chk("R9 sticky flag", v, 32'h1 << 13);
    wr(1, 0, 32'h0);
    rd(1, 4, v);
    chk("R6 flag kept after disable", v, 32'h1 << 13);
    chk("R6 irq kept", {31'h0, irq_out}, 32'h1);
    wr(1, 4, 32'h0);
    rd(1, 4, v);
    chk("R5 write zero", v, 32'h1 << 13);
    wr(1, 4, ~(32'h1 << 13));
    rd(1, 4, v);
    chk("R5 other bits", v, 32'h1 << 13);
    wr(1, 4, 32'h1 << 13);
    rd(1, 4, v);
    chk("R5 write one", v, 32'h0);
    chk("R7 irq after clear", {31'h0, irq_out}, 32'h0);

    // R7: OR across banks
    quiet_all();
    for (int b = 0; b < 3; b++)
      for (int f = 1; f < 4; f++) wr(b, f, 32'h0);
    pins[2] = 1'b1;
    pins[66] = 1'b1;
    wr(0, 0, 32'h1 << 2);
    wr(2, 0, 32'h1 << 2);
    pins[2] = 1'b0;
    pins[66] = 1'b0;
    @(negedge clk);
    chk("R7 two banks set", {31'h0, irq_out}, 32'h1);
    wr(0, 4, 32'h1 << 2);
    chk("R7 one bank left", {31'h0, irq_out}, 32'h1);
    wr(2, 4, 32'h1 << 2);
    chk("R7 none left", {31'h0, irq_out}, 32'h0);

    done = 1;
    summary();
    $finish;
  end
endmodule